// File: doc/BRIEF.md
# Modem Control and Interrupt Section

This block belongs to a single-line synchronous serial controller. It holds the modem control outputs that software writes: data terminal ready, request to send, a shared frequency-select/remote-loopback bit, and local loopback. It also holds the three interrupt enables. Software writes all seven control bits through one write port and can read them back. A device-reset pulse clears every control bit and the latched change flag in a single clock.

Three modem status inputs are asynchronous to the controller clock: clear to send, carrier (receiver ready) and incoming call. Each one passes through a two-flop synchroniser. A small state machine with two states, `DSC_QUIET` and `DSC_PENDING`, latches a data-set-change flag on any edge of any synchronised input. The transitions are:

- QUIET to PENDING when a change is seen.
- PENDING to QUIET when software reads the status.
- Any state to QUIET on device reset.

If a change and a status read happen in the same cycle, the change wins. The flag drives the receive interrupt through its own enable. Receive-data-ready also drives the receive interrupt, and transmit-buffer-empty drives the transmit interrupt. All interrupt requests are levels.

Top module: `mdm_ctl_irq`

## Requirements
- R1: After reset, `ctl_rdata` and all modem and loopback outputs are 0. A write with `ctl_we` high stores `ctl_wdata` in one clock, and `ctl_rdata` returns it. The bit positions are: 0 = shared frequency-select/remote-loopback bit, 1 = data terminal ready (`dtr_o`), 2 = request to send (`rts_o`), 3 = local loopback, 4 = data-set interrupt enable, 5 = receive interrupt enable, 6 = transmit interrupt enable.
- R2: A `dev_reset` pulse clears all seven control bits and `dsc_o` at the next clock edge. When both are asserted, it takes priority over `ctl_we`.
- R3: `cts_s_o`, `carrier_s_o` and `ring_s_o` follow `cts_in`, `carrier_in` and `ring_in` after exactly two clock edges.
- R4: A rising or falling edge on any synchronised modem input sets `dsc_o` on the third clock edge after the raw input changes.
- R5: `dsc_o` stays set until a `stat_rd` pulse clears it at the next edge. If a new change is detected in the same cycle as the read, `dsc_o` stays set.
- R6: `dsc_o` raises `rx_irq_o` only while the data-set interrupt enable (bit 4) is set.
- R7: `rx_data_rdy` raises `rx_irq_o` only while the receive interrupt enable (bit 5) is set.
- R8: `tx_buf_empty` raises `tx_irq_o` only while the transmit interrupt enable (bit 6) is set.
- R9: Each interrupt request is a level. It stays high for as long as its flag and enable are both set, and it falls in the same cycle that either of them drops.
- R10: With `strap_rloop` low, bit 0 drives `sel_freq_o` and `rem_loop_o` stays 0. With `strap_rloop` high, bit 0 drives `rem_loop_o` and `sel_freq_o` stays 0.
- R11: While local loopback (bit 3) is set, `rx_line_o` equals `tx_line_i`. Otherwise `rx_line_o` equals `line_rx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset | input | 1 | Software device-reset pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control write data |
| ctl_rdata | output | 7 | Control register readback |
| stat_rd | input | 1 | Status read pulse, clears change flag |
| cts_in | input | 1 | Clear to send, asynchronous |
| carrier_in | input | 1 | Carrier / receiver ready, asynchronous |
| ring_in | input | 1 | Incoming call, asynchronous |
| strap_rloop | input | 1 | Configuration strap: bit 0 acts as remote loopback |
| rx_data_rdy | input | 1 | Receive data ready from datapath |
| tx_buf_empty | input | 1 | Transmit buffer empty from datapath |
| tx_line_i | input | 1 | Serial transmit data from transmitter |
| line_rx_i | input | 1 | Serial receive data from modem |
| rx_line_o | output | 1 | Serial data to receiver |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| sel_freq_o | output | 1 | Select frequency |
| rem_loop_o | output | 1 | Remote loopback request |
| cts_s_o | output | 1 | Synchronised clear to send |
| carrier_s_o | output | 1 | Synchronised carrier |
| ring_s_o | output | 1 | Synchronised incoming call |
| dsc_o | output | 1 | Data-set-change flag |
| rx_irq_o | output | 1 | Receive-side interrupt request |
| tx_irq_o | output | 1 | Transmit-side interrupt request |

## Verification
The bench tests falling edges as well as rising ones. A detector that only caught rises would leave `dsc_o` low when carrier is lost.

It lands a status read in the same cycle as a fresh change. A design that let the read win would lose that change.

It checks the exact edge on which the synchronised status and the change flag appear. A missing or extra synchroniser stage would show up one cycle early or late.

It also changes the strap and the enables while the flags are held. A design that fed the shared bit to both outputs, or that latched interrupt requests, would show a stale or wrong level at the ports.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int N_MODEM = 3;
    localparam int SYNC_STAGES = 2;
    localparam int CTL_W = 7;

    typedef enum logic {
        DSC_QUIET   = 1'b0,
        DSC_PENDING = 1'b1
    } dsc_state_t;

    typedef struct packed {
        logic tx_ie;
        logic rx_ie;
        logic ds_ie;
        logic lloop;
        logic rts;
        logic dtr;
        logic sfrl;
    } ctl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_dsc.sv
module mdm_dsc
    import mdm_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dev_rst,
    input  logic         rd,
    input  logic [W-1:0] sync_in,
    output logic         pending
);
    dsc_state_t   state, state_nx;
    logic [W-1:0] prev;
    logic         edge_seen;

    assign edge_seen = |(sync_in ^ prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DSC_QUIET;
            prev  <= '0;
        end else begin
            state <= state_nx;
            prev  <= sync_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DSC_QUIET:   if (edge_seen) state_nx = DSC_PENDING;
            DSC_PENDING: if (rd && !edge_seen) state_nx = DSC_QUIET;
            default:     state_nx = DSC_QUIET;
        endcase
        if (dev_rst) state_nx = DSC_QUIET;
    end

    assign pending = (state == DSC_PENDING);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rd && !dev_rst) |=> pending);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !edge_seen && !dev_rst) |=> !pending);
    p_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !dev_rst) |=> pending);
endmodule

// File: rtl/mdm_irq.sv
module mdm_irq (
    input  logic dsc,
    input  logic ds_ie,
    input  logic rx_rdy,
    input  logic rx_ie,
    input  logic tx_empty,
    input  logic tx_ie,
    output logic rx_irq,
    output logic tx_irq
);
    assign rx_irq = (dsc && ds_ie) || (rx_rdy && rx_ie);
    assign tx_irq = tx_empty && tx_ie;
endmodule

// File: rtl/mdm_ctl_irq.sv
module mdm_ctl_irq
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_reset,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             stat_rd,
    input  logic             cts_in,
    input  logic             carrier_in,
    input  logic             ring_in,
    input  logic             strap_rloop,
    input  logic             rx_data_rdy,
    input  logic             tx_buf_empty,
    input  logic             tx_line_i,
    input  logic             line_rx_i,
    output logic             rx_line_o,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             sel_freq_o,
    output logic             rem_loop_o,
    output logic             cts_s_o,
    output logic             carrier_s_o,
    output logic             ring_s_o,
    output logic             dsc_o,
    output logic             rx_irq_o,
    output logic             tx_irq_o
);
    ctl_t               ctl_q;
    logic [N_MODEM-1:0] modem_raw, modem_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctl_q <= '0;
        else if (dev_reset) ctl_q <= '0;
        else if (ctl_we)    ctl_q <= ctl_t'(ctl_wdata);
    end

    assign modem_raw = {ring_in, carrier_in, cts_in};

    mdm_sync #(.W(N_MODEM), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(modem_raw), .dout(modem_s)
    );

    mdm_dsc #(.W(N_MODEM)) u_dsc (
        .clk(clk), .rst_n(rst_n), .dev_rst(dev_reset), .rd(stat_rd),
        .sync_in(modem_s), .pending(dsc_o)
    );

    mdm_irq u_irq (
        .dsc(dsc_o), .ds_ie(ctl_q.ds_ie),
        .rx_rdy(rx_data_rdy), .rx_ie(ctl_q.rx_ie),
        .tx_empty(tx_buf_empty), .tx_ie(ctl_q.tx_ie),
        .rx_irq(rx_irq_o), .tx_irq(tx_irq_o)
    );

    assign ctl_rdata   = ctl_q;
    assign dtr_o       = ctl_q.dtr;
    assign rts_o       = ctl_q.rts;
    assign sel_freq_o  = ctl_q.sfrl && !strap_rloop;
    assign rem_loop_o  = ctl_q.sfrl && strap_rloop;
    assign rx_line_o   = ctl_q.lloop ? tx_line_i : line_rx_i;
    assign cts_s_o     = modem_s[0];
    assign carrier_s_o = modem_s[1];
    assign ring_s_o    = modem_s[2];

    p_devrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (ctl_rdata == '0 && !dsc_o));
    p_txirq_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o |-> ctl_q.tx_ie);
    p_rxirq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> ((dsc_o && ctl_q.ds_ie) || (rx_data_rdy && ctl_q.rx_ie)));
    p_strap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_freq_o && rem_loop_o));
endmodule

// File: tb/mdm_ctl_irq_test.sv
`timescale 1ns/100ps
module mdm_ctl_irq_test;
    logic       clk = 0, rst_n = 0, dev_reset = 0, ctl_we = 0, stat_rd = 0;
    logic [6:0] ctl_wdata = 0;
    logic [6:0] ctl_rdata;
    logic cts_in = 0, carrier_in = 0, ring_in = 0, strap_rloop = 0;
    logic rx_data_rdy = 0, tx_buf_empty = 0, tx_line_i = 0, line_rx_i = 0;
    logic rx_line_o, dtr_o, rts_o, sel_freq_o, rem_loop_o;
    logic cts_s_o, carrier_s_o, ring_s_o, dsc_o, rx_irq_o, tx_irq_o;

    int checks = 0, errors = 0;
    logic [6:0] m_ctl = 0;

    always #2.5 clk = ~clk;

    mdm_ctl_irq uut (.*);

    function automatic logic f_rx(logic dsc, logic [6:0] c, logic rdy);
        return (dsc & c[4]) | (rdy & c[5]);
    endfunction
    function automatic logic f_tx(logic [6:0] c, logic emp);
        return emp & c[6];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [6:0] d);
        ctl_wdata = d; ctl_we = 1; step(); ctl_we = 0; m_ctl = d;
    endtask

    task automatic chk_all(input string tag);
        chk(ctl_rdata == m_ctl, {tag, " R1 readback"}, ctl_rdata, m_ctl);
        chk(rx_irq_o == f_rx(dsc_o, m_ctl, rx_data_rdy), {tag, " R7 rx_irq"}, rx_irq_o, f_rx(dsc_o, m_ctl, rx_data_rdy));
        chk(tx_irq_o == f_tx(m_ctl, tx_buf_empty), {tag, " R8 tx_irq"}, tx_irq_o, f_tx(m_ctl, tx_buf_empty));
        chk(sel_freq_o == (m_ctl[0] & ~strap_rloop) && rem_loop_o == (m_ctl[0] & strap_rloop),
            {tag, " R10 strap"}, {sel_freq_o, rem_loop_o}, {m_ctl[0] & ~strap_rloop, m_ctl[0] & strap_rloop});
        chk(rx_line_o == (m_ctl[3] ? tx_line_i : line_rx_i), {tag, " R11 loopback"}, rx_line_o, m_ctl[3] ? tx_line_i : line_rx_i);
        chk(dtr_o == m_ctl[1] && rts_o == m_ctl[2], {tag, " R1 modem outs"}, {dtr_o, rts_o}, {m_ctl[1], m_ctl[2]});
    endtask

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        step(); step(); rst_n = 1; step();
        // R1 reset state
        chk(ctl_rdata == 0 && !dsc_o && !rx_irq_o && !tx_irq_o && !dtr_o && !rts_o,
            "R1 reset state", {ctl_rdata, dsc_o}, 0);

        // R3 / R4: rising edge on cts
        cts_in = 1;
        step();
        chk(cts_s_o == 0, "R3 one edge", cts_s_o, 0);
        step();
        chk(cts_s_o == 1 && dsc_o == 0, "R3 two edges", {cts_s_o, dsc_o}, 2'b10);
        step();
        chk(dsc_o == 1, "R4 rise sets dsc", dsc_o, 1);
        chk(rx_irq_o == 0, "R6 no irq without enable", rx_irq_o, 0);
        wr(7'h10);
        chk(rx_irq_o == 1, "R6 irq with ds enable", rx_irq_o, 1);
        step(); step();
        chk(dsc_o == 1 && rx_irq_o == 1, "R9 level holds", {dsc_o, rx_irq_o}, 2'b11);
        wr(7'h00);
        chk(rx_irq_o == 0 && dsc_o == 1, "R9 drop on enable clear", {dsc_o, rx_irq_o}, 2'b10);
        wr(7'h10);
        // R5 read clears
        stat_rd = 1; step(); stat_rd = 0;
        chk(dsc_o == 0 && rx_irq_o == 0, "R5 read clears", {dsc_o, rx_irq_o}, 0);

        // R4 falling edge on cts, then carrier rise
        cts_in = 0; step(); step(); step();
        chk(dsc_o == 1 && cts_s_o == 0, "R4 fall sets dsc", {dsc_o, cts_s_o}, 2'b10);
        // R5 read collides with fresh ring change
        ring_in = 1; step(); step();
        stat_rd = 1; step(); stat_rd = 0;
        chk(dsc_o == 1, "R5 change beats read", dsc_o, 1);
        chk(ring_s_o == 1, "R3 ring synced", ring_s_o, 1);
        stat_rd = 1; step(); stat_rd = 0;
        chk(dsc_o == 0, "R5 later read clears", dsc_o, 0);
        carrier_in = 1; step(); step(); step();
        chk(dsc_o == 1 && carrier_s_o == 1, "R4 carrier rise", {dsc_o, carrier_s_o}, 2'b11);

        // R2 device reset clears everything, beats write
        wr(7'h7f);
        ctl_we = 1; ctl_wdata = 7'h55; dev_reset = 1; step();
        ctl_we = 0; dev_reset = 0; m_ctl = 0;
        chk(ctl_rdata == 0 && dsc_o == 0, "R2 device reset", {ctl_rdata, dsc_o}, 0);
        chk(!rx_irq_o && !tx_irq_o, "R2 irqs cleared", {rx_irq_o, tx_irq_o}, 0);

        // R7/R8/R9 directed
        rx_data_rdy = 1; tx_buf_empty = 1; #1;
        chk(!rx_irq_o && !tx_irq_o, "R7 R8 no enable", {rx_irq_o, tx_irq_o}, 0);
        wr(7'h60);
        chk(rx_irq_o && tx_irq_o, "R7 R8 enabled", {rx_irq_o, tx_irq_o}, 2'b11);
        tx_buf_empty = 0; #1;
        chk(!tx_irq_o && rx_irq_o, "R9 tx drops with flag", {rx_irq_o, tx_irq_o}, 2'b10);
        rx_data_rdy = 0; #1;
        chk(!rx_irq_o, "R9 rx drops with flag", rx_irq_o, 0);

        // R10 / R11 directed
        wr(7'h09); strap_rloop = 0; tx_line_i = 1; line_rx_i = 0; #1;
        chk(sel_freq_o && !rem_loop_o && rx_line_o, "R10 R11 strap low loop on", {sel_freq_o, rem_loop_o, rx_line_o}, 3'b101);
        strap_rloop = 1; #1;
        chk(!sel_freq_o && rem_loop_o, "R10 strap high", {sel_freq_o, rem_loop_o}, 2'b01);
        wr(7'h00); #1;
        chk(rx_line_o == 0 && !rem_loop_o, "R11 loop off", rx_line_o, 0);

        // constrained random phase, modem inputs steady, dsc cleared
        stat_rd = 1; step(); stat_rd = 0;
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                ctl_wdata = 7'($urandom); ctl_we = 1; step(); ctl_we = 0; m_ctl = ctl_wdata;
            end else step();
            rx_data_rdy  = 1'($urandom);
            tx_buf_empty = 1'($urandom);
            strap_rloop  = 1'($urandom);
            tx_line_i    = 1'($urandom);
            line_rx_i    = 1'($urandom);
            #1;
            chk_all("rand");
            chk(dsc_o == 0, "rand R5 dsc stays clear", dsc_o, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule